// File: doc/BRIEF.md
# Banked General Register File

This block is the general register storage of a small 8-bit processor. Software sees four register numbers. Number 0 is the accumulator, and it is always the same physical register. Numbers 1 to 3 each exist twice, once in each of two banks. A bank-select bit, driven from the processor's lower status word, picks which copy of registers 1 to 3 the register numbers refer to.

Flipping that bit swaps the whole working set in one step. Interrupt entry code can therefore get a private set of general registers without saving or restoring anything. The accumulator remains common to both sets, so a value can be handed across the switch.

The file has two combinational read ports and one write port that updates on the clock edge. All three ports are addressed by a 2-bit register number, and all three resolve the bank from the same select input.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous active-high reset clears all seven physical registers to zero. After reset, every register number read under either bank setting returns 0x00.
- R2: Register number 0 maps to one shared accumulator. A value written to it under either bank setting is read back under both bank settings.
- R3: Register numbers 1, 2 and 3 each map to two separate physical registers. `bankSel`=0 selects the first copy and `bankSel`=1 selects the second copy.
- R4: A write to register number 1, 2 or 3 under one bank setting leaves that register number's copy in the other bank unchanged.
- R5: Reads are combinational and follow the present `bankSel` value. When `bankSel` changes, the read data of registers 1 to 3 switches within the same cycle, with no clock edge needed.
- R6: A write takes effect on the rising clock edge and goes to the bank that `bankSel` selects in that cycle.
- R7: When a read and a write target the same physical register in the same cycle, the read returns the old value. The new value is readable from the next cycle on.
- R8: The two read ports are independent. Whenever both address the same register number, they return the same data.
- R9: With `wrEn` low, a clock edge changes no register.
- R10: Reset has priority over a write that is requested in the same cycle. The targeted register reads 0x00 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the write and the reset act on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bankSel | input | 1 | Selects the bank of registers 1 to 3 |
| rdAddrA | input | 2 | Register number for read port A |
| rdDataA | output | 8 | Read port A data (combinational) |
| rdAddrB | input | 2 | Register number for read port B |
| rdDataB | output | 8 | Read port B data (combinational) |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 2 | Register number to write |
| wrData | input | 8 | Data to write |

## Verification
A wrong bank decode shows up in the cycle after the first write to registers 1 to 3: the write lands in, or is read from, the other bank's copy. A faulty accumulator mapping shows as a value written under one bank that is missing when read under the other bank. A missing write-enable gate or a missing reset priority corrupts the very next read of the targeted register. Because the reads are combinational, any wrong stored state is visible at both read ports one clock after the faulty edge, as soon as the bench addresses that register.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
  localparam int DATA_W     = 8;
  localparam int REG_ADDR_W = 2;
  localparam int NUM_BANKS  = 2;
  localparam int BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int NUM_ARCH   = 1 << REG_ADDR_W;
  localparam int PHYS_REGS  = 1 + (NUM_ARCH - 1) * NUM_BANKS;
  localparam int PHYS_IDX_W = $clog2(PHYS_REGS);

  typedef logic [PHYS_IDX_W-1:0] physIdx_t;

  // strobes from the decode (control) to the storage (datapath)
  typedef struct packed {
    logic [PHYS_REGS-1:0] wrHot;
    physIdx_t             rdIdxA;
    physIdx_t             rdIdxB;
  } regStrobe_t;

  // register number 0 is shared; others are laid out bank-interleaved
  function automatic physIdx_t mapPhys(input logic [REG_ADDR_W-1:0] addr,
                                       input logic [BANK_W-1:0] bank);
    int idx;
    if (addr == '0) idx = 0;
    else idx = 1 + (int'(addr) - 1) * NUM_BANKS + int'(bank);
    return physIdx_t'(idx);
  endfunction
endpackage

// File: rtl/bankreg_ctrl.sv
module bankreg_ctrl
  import bankreg_pkg::*;
(
  input  logic                  bankSel,
  input  logic [REG_ADDR_W-1:0] rdAddrA,
  input  logic [REG_ADDR_W-1:0] rdAddrB,
  input  logic                  wrEn,
  input  logic [REG_ADDR_W-1:0] wrAddr,
  output regStrobe_t            strobe
);
  physIdx_t wrIdx;

  always_comb begin
    wrIdx         = mapPhys(wrAddr, BANK_W'(bankSel));
    strobe.rdIdxA = mapPhys(rdAddrA, BANK_W'(bankSel));
    strobe.rdIdxB = mapPhys(rdAddrB, BANK_W'(bankSel));
  end

  generate
    for (genvar i = 0; i < PHYS_REGS; i++) begin : g_wrDec
      assign strobe.wrHot[i] = wrEn && (wrIdx == physIdx_t'(i));
    end
  endgenerate
endmodule

// File: rtl/bankreg_dp.sv
module bankreg_dp
  import bankreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);
  logic [PHYS_REGS*DATA_W-1:0] regFlat;

  generate
    for (genvar i = 0; i < PHYS_REGS; i++) begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else if (strobe.wrHot[i]) q <= wrData;
      end
      assign regFlat[i*DATA_W +: DATA_W] = q;
    end
  endgenerate

  always_comb begin
    rdDataA = '0;
    rdDataB = '0;
    for (int i = 0; i < PHYS_REGS; i++) begin
      if (strobe.rdIdxA == physIdx_t'(i)) rdDataA = regFlat[i*DATA_W +: DATA_W];
      if (strobe.rdIdxB == physIdx_t'(i)) rdDataB = regFlat[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bankreg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bankSel,
  input  logic [REG_ADDR_W-1:0] rdAddrA,
  output logic [DATA_W-1:0]     rdDataA,
  input  logic [REG_ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0]     rdDataB,
  input  logic                  wrEn,
  input  logic [REG_ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0]     wrData
);
  regStrobe_t strobe;

  bankreg_ctrl u_ctrl (
    .bankSel(bankSel), .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .wrEn(wrEn), .wrAddr(wrAddr), .strobe(strobe)
  );

  bankreg_dp u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .wrData(wrData),
    .rdDataA(rdDataA), .rdDataB(rdDataB)
  );
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk
  import bankreg_pkg::*;
(
  input logic                  clk,
  input logic                  rst,
  input logic                  bankSel,
  input logic [REG_ADDR_W-1:0] rdAddrA,
  input logic [DATA_W-1:0]     rdDataA,
  input logic [REG_ADDR_W-1:0] rdAddrB,
  input logic [DATA_W-1:0]     rdDataB,
  input logic                  wrEn,
  input logic [REG_ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0]     wrData
);
  // R1: the first cycle out of reset reads zero on both ports
  p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rdDataA == '0 && rdDataB == '0));

  // R6, R2, R3: a write is read back next cycle at the same register and bank
  p_write_back_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(wrEn) && !$past(rst) && $past(wrAddr) == rdAddrA &&
     (rdAddrA == '0 || $past(bankSel) == bankSel))
    |-> rdDataA == $past(wrData));

  // R2: accumulator written under any bank is seen under any bank
  p_shared_acc_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(wrEn) && !$past(rst) && $past(wrAddr) == '0 && rdAddrB == '0)
    |-> rdDataB == $past(wrData));

  // R9: no write, same address and bank -> read data holds
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wrEn) && $stable(rdAddrA) && $stable(bankSel))
    |-> $stable(rdDataA));

  // R8: both ports agree when they address the same register
  p_ports_agree_r8: assert property (@(posedge clk) disable iff (rst)
    (rdAddrA == rdAddrB) |-> (rdDataA == rdDataB));
endmodule

bind banked_regfile banked_regfile_chk u_chk (.*);

// File: tb/sim_banked_regfile.sv
`timescale 1ns/1ps
module sim_banked_regfile;
  logic       clk = 0;
  logic       rst = 1;
  logic       bankSel = 0;
  logic [1:0] rdAddrA = 0, rdAddrB = 0, wrAddr = 0;
  logic       wrEn = 0;
  logic [7:0] wrData = 0;
  logic [7:0] rdDataA, rdDataB;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] model [7];

  always #5 clk = ~clk;

  banked_regfile u0 (
    .clk(clk), .rst(rst), .bankSel(bankSel),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData)
  );

  function automatic int physOf(logic [1:0] a, logic b);
    return (a == 0) ? 0 : 1 + (int'(a) - 1) * 2 + int'(b);
  endfunction

  function automatic logic [7:0] expRead(logic [1:0] a, logic b);
    return model[physOf(a, b)];
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  // apply the model update for the edge that just passed
  task automatic tick();
    logic r, w, b; logic [1:0] a; logic [7:0] d;
    r = rst; w = wrEn; b = bankSel; a = wrAddr; d = wrData;
    @(posedge clk);
    if (r) foreach (model[i]) model[i] = 8'h00;
    else if (w) model[physOf(a, b)] = d;
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic b, logic [7:0] d);
    wrEn = 1; wrAddr = a; bankSel = b; wrData = d;
    tick();
    wrEn = 0;
  endtask

  task automatic rd(string req, logic [1:0] a, logic b, logic [7:0] exp);
    rdAddrA = a; rdAddrB = a; bankSel = b; #1;
    chk(req, rdDataA, exp);
    chk(req, rdDataB, exp);
  endtask

  initial begin
    foreach (model[i]) model[i] = 8'hxx;
    @(negedge clk);
    tick(); tick();
    rst = 0;
    // R1: reset state under every address and bank
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < 4; a++) rd("R1", 2'(a), 1'(b), 8'h00);

    // R2: accumulator shared across banks
    wr(2'd0, 1'b0, 8'h3C);
    rd("R2", 2'd0, 1'b1, 8'h3C);
    wr(2'd0, 1'b1, 8'hC3);
    rd("R2", 2'd0, 1'b0, 8'hC3);

    // R3, R4, R6: two copies per register number
    wr(2'd2, 1'b0, 8'hAA);
    wr(2'd2, 1'b1, 8'h55);
    rd("R3", 2'd2, 1'b0, 8'hAA);
    rd("R4", 2'd2, 1'b1, 8'h55);
    wr(2'd3, 1'b1, 8'h77);
    rd("R6", 2'd3, 1'b1, 8'h77);
    rd("R4", 2'd3, 1'b0, 8'h00);

    // R5: bank switch within one cycle, no edge in between
    rdAddrA = 2'd2; bankSel = 0; #1; chk("R5", rdDataA, 8'hAA);
    bankSel = 1; #1; chk("R5", rdDataA, 8'h55);
    bankSel = 0; #1; chk("R5", rdDataA, 8'hAA);
    @(negedge clk);

    // R7: same-cycle write and read return old value, new one next cycle
    wrEn = 1; wrAddr = 2'd1; bankSel = 0; wrData = 8'h99; rdAddrA = 2'd1; #1;
    chk("R7", rdDataA, 8'h00);
    tick(); wrEn = 0; #1;
    chk("R7", rdDataA, 8'h99);

    // R8: ports independent
    rdAddrA = 2'd1; rdAddrB = 2'd2; bankSel = 0; #1;
    chk("R8", rdDataA, 8'h99); chk("R8", rdDataB, 8'hAA);

    // R9: write enable low leaves storage untouched
    wrEn = 0; wrAddr = 2'd1; wrData = 8'hEE; bankSel = 0;
    tick();
    rd("R9", 2'd1, 1'b0, 8'h99);

    // R10: reset beats a simultaneous write
    rst = 1; wrEn = 1; wrAddr = 2'd2; bankSel = 1; wrData = 8'h11;
    tick();
    rst = 0; wrEn = 0;
    rd("R10", 2'd2, 1'b1, 8'h00);
    rd("R1", 2'd0, 1'b0, 8'h00);

    // random mix
    void'($urandom(32'h2650));
    for (int n = 0; n < 600; n++) begin
      rst     = ($urandom % 40) == 0;
      wrEn    = $urandom % 2;
      wrAddr  = 2'($urandom);
      wrData  = 8'($urandom);
      bankSel = 1'($urandom);
      rdAddrA = 2'($urandom);
      rdAddrB = 2'($urandom);
      #1;
      chk("R3", rdDataA, expRead(rdAddrA, bankSel));
      chk("R8", rdDataB, expRead(rdAddrB, bankSel));
      tick();
    end
    rst = 0; wrEn = 0;

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule